// File: doc/BRIEF.md
# Four-Neuron Integrate-and-Fire Tile with Shared Worker

This block keeps the state of four integrate-and-fire neurons arranged as a two-by-two grid and updates them with a single integrate-and-compare worker. An input event carries a signed synaptic weight and a row/column address. It is taken over a ready/valid handshake into a one-entry pending slot that belongs to the addressed neuron. The worker visits the neurons that have pending events in round-robin order. For each one it adds the weight to that neuron's membrane potential with saturation, then compares the result with the neuron's threshold.

When the new potential reaches the threshold, the neuron fires. Its potential returns to zero and the tile pulses an output flit. The flit carries the weight that caused the firing and the address of the source neuron. Byte-level decoding of the input stream and configuration traffic are handled upstream. This tile sees only decoded events.

Top module: `spk_neuron_tile`

## Requirements
- R1: The neuron index is 2·row + col. In an output flit, bit 2 holds the source row bit and bit 0 holds the source column bit.
- R2: After the active-low reset, every potential is zero, every threshold is 7, no event is pending, `in_ready` is high for every address and `out_valid` is low.
- R3: Adding a weight to a potential saturates to the signed 4-bit range −8..+7. It never wraps.
- R4: When the saturated sum is greater than or equal to the neuron's threshold, the neuron fires. Its potential becomes zero, and exactly one flit is emitted. The flit holds the causing event's weight in bits [7:4] and zero in bits 3 and 1. When the sum is below the threshold, it becomes the new potential and no flit is emitted.
- R5: On a freshly reset neuron, seven +1 events produce one flit, and it comes on the seventh event. A single +7 event fires at once.
- R6: Events aimed at different neurons, even when interleaved cycle by cycle, update only their own neuron's potential.
- R7: The worker serves pending neurons in round-robin order. It starts at the index after the one it served last and wraps from 3 to 0.
- R8: `in_ready` is high exactly when the addressed neuron has no pending event. An event is taken on a cycle where both `in_valid` and `in_ready` are high.
- R9: `out_valid` is a single-cycle pulse per firing, and it is never high on two consecutive cycles.
- R10: Negative weights lower the potential. It holds at −8 under further negative input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input event offered |
| in_weight | input | 4 | Signed synaptic weight of the event |
| in_row | input | 1 | Row bit of the target neuron |
| in_col | input | 1 | Column bit of the target neuron |
| in_ready | output | 1 | Addressed neuron's pending slot is free |
| out_valid | output | 1 | Output flit valid this cycle |
| out_flit | output | 8 | Weight in [7:4], row in bit 2, column in bit 0 |

## Verification
On every cycle, the bound checker confirms four things. The valid strobe is a lone pulse, and the reserved flit bits are zero. No flit appears without an earlier accepted event. No stored potential is ever at or above its threshold after writeback, which is what reset-on-fire implies.

Only the bench's scenarios can show the rest. These are the arithmetic of saturation at both rails, the seven-event firing count, independence between interleaved neurons, the exact round-robin service order, and the per-address ready behaviour. The bench checks them against a reference model that it computes itself, including a sweep over every pair of weights.

// File: rtl/spk_pkg.sv
package spk_pkg;

    typedef enum logic {
        W_IDLE = 1'b0,
        W_EXEC = 1'b1
    } wstate_e;

endpackage

// File: rtl/spk_rr_pick.sv
module spk_rr_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] ptr,
    output logic          gnt_valid,
    output logic [IW-1:0] gnt_idx
);
    logic [IW-1:0] cand;

    // Scan from the farthest candidate back to ptr so the nearest request wins.
    always_comb begin
        gnt_valid = |req;
        gnt_idx   = '0;
        cand      = '0;
        for (int k = N - 1; k >= 0; k--) begin
            cand = IW'((int'(ptr) + k) % N);
            if (req[cand]) begin
                gnt_idx = cand;
            end
        end
    end

endmodule

// File: rtl/spk_sat_add.sv
module spk_sat_add #(
    parameter int W = 4
) (
    input  logic signed [W-1:0] pot,
    input  logic signed [W-1:0] wgt,
    input  logic signed [W-1:0] thr,
    output logic signed [W-1:0] sum,
    output logic                fire
);
    localparam logic signed [W:0] HI = $signed({2'b00, {(W-1){1'b1}}});
    localparam logic signed [W:0] LO = $signed({2'b11, {(W-1){1'b0}}});

    logic signed [W:0] wide;

    always_comb begin
        wide = $signed({pot[W-1], pot}) + $signed({wgt[W-1], wgt});
        if (wide > HI) begin
            sum = HI[W-1:0];
        end else if (wide < LO) begin
            sum = LO[W-1:0];
        end else begin
            sum = wide[W-1:0];
        end
        fire = (sum >= thr);
    end

endmodule

// File: rtl/spk_neuron_tile.sv
module spk_neuron_tile #(
    parameter int WEIGHT_W    = 4,
    parameter int THRESH_INIT = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [WEIGHT_W-1:0]   in_weight,
    input  logic                  in_row,
    input  logic                  in_col,
    output logic                  in_ready,
    output logic                  out_valid,
    output logic [WEIGHT_W+3:0]   out_flit
);
    import spk_pkg::*;

    localparam int N  = 4;
    localparam int IW = 2;
    localparam int FW = WEIGHT_W + 4;
    localparam logic [WEIGHT_W-1:0] THR_RST = WEIGHT_W'(THRESH_INIT);

    typedef struct packed {
        wstate_e                          st;
        logic [N-1:0]                     pend;
        logic [N-1:0][WEIGHT_W-1:0]       accum;
        logic [N-1:0][WEIGHT_W-1:0]       vm;
        logic [N-1:0][WEIGHT_W-1:0]       thr;
        logic [IW-1:0]                    rr;
        logic [IW-1:0]                    sel;
        logic [WEIGHT_W-1:0]              cur_w;
        logic                             ov;
        logic [FW-1:0]                    flit;
    } tile_t;

    tile_t q, d;

    logic [IW-1:0]          in_idx;
    logic                   accept;
    logic                   gnt_valid;
    logic [IW-1:0]          gnt_idx;
    logic [WEIGHT_W-1:0]    sum_w;
    logic                   fire_w;
    logic [N*WEIGHT_W-1:0]  vm_flat;
    logic [N*WEIGHT_W-1:0]  thr_flat;

    assign in_idx    = {in_row, in_col};
    assign in_ready  = ~q.pend[in_idx];
    assign accept    = in_valid & in_ready;
    assign out_valid = q.ov;
    assign out_flit  = q.flit;
    assign vm_flat   = q.vm;
    assign thr_flat  = q.thr;

    spk_rr_pick #(
        .N  (N),
        .IW (IW)
    ) u_pick (
        .req       (q.pend),
        .ptr       (q.rr),
        .gnt_valid (gnt_valid),
        .gnt_idx   (gnt_idx)
    );

    spk_sat_add #(
        .W (WEIGHT_W)
    ) u_add (
        .pot  (q.vm[q.sel]),
        .wgt  (q.cur_w),
        .thr  (q.thr[q.sel]),
        .sum  (sum_w),
        .fire (fire_w)
    );

    always_comb begin
        d    = q;
        d.ov = 1'b0;

        unique case (q.st)
            W_IDLE: begin
                if (gnt_valid) begin
                    d.st            = W_EXEC;
                    d.sel           = gnt_idx;
                    d.cur_w         = q.accum[gnt_idx];
                    d.pend[gnt_idx] = 1'b0;
                    d.rr            = gnt_idx + 1'b1;
                end
            end
            W_EXEC: begin
                d.st = W_IDLE;
                if (fire_w) begin
                    d.vm[q.sel] = '0;
                    d.ov        = 1'b1;
                    d.flit      = {q.cur_w, 1'b0, q.sel[1], 1'b0, q.sel[0]};
                end else begin
                    d.vm[q.sel] = sum_w;
                end
            end
            default: d.st = W_IDLE;
        endcase

        // The granted slot was already full, so no new event can land on it here.
        if (accept) begin
            d.pend[in_idx]  = 1'b1;
            d.accum[in_idx] = in_weight;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st    <= W_IDLE;
            q.pend  <= '0;
            q.accum <= '0;
            q.vm    <= '0;
            q.thr   <= {N{THR_RST}};
            q.rr    <= '0;
            q.sel   <= '0;
            q.cur_w <= '0;
            q.ov    <= 1'b0;
            q.flit  <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/spk_tile_checker.sv
module spk_tile_checker #(
    parameter int W = 4,
    parameter int N = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_ready,
    input  logic             out_valid,
    input  logic [W+3:0]     out_flit,
    input  logic [N*W-1:0]   vm_flat,
    input  logic [N*W-1:0]   thr_flat
);
    logic [31:0] acc_cnt_q;
    logic [31:0] out_cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_cnt_q <= '0;
            out_cnt_q <= '0;
        end else begin
            if (in_valid && in_ready) acc_cnt_q <= acc_cnt_q + 1;
            if (out_valid)            out_cnt_q <= out_cnt_q + 1;
        end
    end

    // R9: a firing produces a lone one-cycle strobe
    assert_flit_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R4: reserved flit bits stay zero
    assert_flit_reserved_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_flit[3] == 1'b0 && out_flit[1] == 1'b0));

    // R4: every flit is caused by an event accepted earlier
    assert_no_orphan_flit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_cnt_q < acc_cnt_q));

    // R4: a stored potential never sits at or above its threshold
    for (genvar i = 0; i < N; i++) begin : g_vm
        assert_vm_below_thr_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $signed(vm_flat[i*W +: W]) < $signed(thr_flat[i*W +: W]));
    end

endmodule

bind spk_neuron_tile spk_tile_checker #(
    .W (WEIGHT_W),
    .N (4)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_flit  (out_flit),
    .vm_flat   (vm_flat),
    .thr_flat  (thr_flat)
);

// File: tb/spk_neuron_tile_bench.sv
`timescale 1ns/1ps
module spk_neuron_tile_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [3:0] in_weight = '0;
    logic       in_row = 1'b0;
    logic       in_col = 1'b0;
    logic       in_ready;
    logic       out_valid;
    logic [7:0] out_flit;

    always #2 clk = ~clk;

    spk_neuron_tile u_spk_neuron_tile (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_weight (in_weight),
        .in_row    (in_row),
        .in_col    (in_col),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_flit  (out_flit)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int ref_vm [4];
    logic [7:0] expf [4][64];
    int ehead [4];
    int etail [4];
    int fires_seen [4];
    int order_log [16];
    int nlog = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Reference model: saturating add, fire at >= 7, reset to zero.
    task automatic model(input int w, input int n);
        int s;
        s = ref_vm[n] + w;
        if (s > 7)  s = 7;
        if (s < -8) s = -8;
        if (s >= 7) begin
            expf[n][etail[n] % 64] = {4'(w), 1'b0, 1'(n >> 1), 1'b0, 1'(n & 1)};
            etail[n]++;
            ref_vm[n] = 0;
        end else begin
            ref_vm[n] = s;
        end
    endtask

    task automatic send(input int w, input int n);
        @(negedge clk);
        in_valid  = 1'b1;
        in_weight = 4'(w);
        in_row    = 1'(n >> 1);
        in_col    = 1'(n & 1);
        #0.1;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        model(w, n);
    endtask

    task automatic idle(input int cycles);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (cycles) @(negedge clk);
    endtask

    // Flit monitor, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            int n;
            n = {out_flit[2], out_flit[0]};
            if (nlog < 16) order_log[nlog] = n;
            nlog++;
            fires_seen[n]++;
            if (ehead[n] == etail[n]) begin
                chk(1'b0, "R4 unexpected flit", int'(out_flit), -1);
            end else begin
                chk(out_flit == expf[n][ehead[n] % 64], "R1/R3/R4 flit content",
                    int'(out_flit), int'(expf[n][ehead[n] % 64]));
                ehead[n]++;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        int f0;
        for (int i = 0; i < 4; i++) begin
            ref_vm[i] = 0; ehead[i] = 0; etail[i] = 0; fires_seen[i] = 0;
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R2: reset state at every address
        for (int a = 0; a < 4; a++) begin
            in_row = 1'(a >> 1); in_col = 1'(a & 1);
            #0.1;
            chk(in_ready == 1'b1, "R2 ready after reset", int'(in_ready), 1);
        end
        chk(out_valid == 1'b0, "R2 valid low after reset", int'(out_valid), 0);

        // R7: back-to-back +7 events to 3,2,1,0 are served in order 3,1,2,0
        send(7, 3); send(7, 2); send(7, 1); send(7, 0);
        idle(12);
        chk(nlog == 4, "R7 flit count", nlog, 4);
        chk(order_log[0] == 3, "R7 order slot0", order_log[0], 3);
        chk(order_log[1] == 1, "R7 order slot1", order_log[1], 1);
        chk(order_log[2] == 2, "R7 order slot2", order_log[2], 2);
        chk(order_log[3] == 0, "R7 order slot3", order_log[3], 0);

        // R5: seven +1 events fire once, on the seventh
        f0 = fires_seen[0];
        for (int i = 0; i < 6; i++) begin send(1, 0); idle(3); end
        chk(fires_seen[0] == f0, "R5 no fire before seventh", fires_seen[0], f0);
        send(1, 0); idle(4);
        chk(fires_seen[0] == f0 + 1, "R5 fire on seventh", fires_seen[0], f0 + 1);

        // R6: interleaved neurons keep separate state
        send(3, 0); send(7, 3); idle(6);
        chk(fires_seen[3] == 2, "R6 neuron 3 fired", fires_seen[3], 2);
        chk(fires_seen[0] == f0 + 1, "R6 neuron 0 held", fires_seen[0], f0 + 1);
        send(4, 0); idle(4);
        chk(fires_seen[0] == f0 + 2, "R6 neuron 0 reaches 7", fires_seen[0], f0 + 2);

        // R8: ready drops for an occupied slot only, then returns
        idle(3);
        send(2, 1);
        @(negedge clk);
        in_valid = 1'b0; in_row = 1'b0; in_col = 1'b1;
        #0.1;
        chk(in_ready == 1'b0, "R8 ready low on full slot", int'(in_ready), 0);
        in_col = 1'b0;
        #0.1;
        chk(in_ready == 1'b1, "R8 ready high on other slot", int'(in_ready), 1);
        @(negedge clk);
        in_col = 1'b1;
        #0.1;
        chk(in_ready == 1'b1, "R8 ready back after dispatch", int'(in_ready), 1);
        idle(4);

        // R10 and R3: negative rail, then positive rail
        for (int i = 0; i < 10; i++) send(-1, 2);
        idle(4);
        send(7, 2); send(7, 2); idle(6);
        chk(fires_seen[2] == 1, "R3/R10 no wrap at -8", fires_seen[2], 1);
        send(1, 2); idle(4);
        chk(fires_seen[2] == 2, "R10 fires from -8 path", fires_seen[2], 2);
        send(6, 2); send(7, 2); idle(6);
        chk(fires_seen[2] == 3, "R3 saturate at +7", fires_seen[2], 3);

        // R3/R4/R6: every ordered pair of weights, rotating over neurons
        for (int a = -8; a < 8; a++) begin
            for (int b = -8; b < 8; b++) begin
                send(a, (a + b + 16) % 4);
                send(b, (a + b + 16) % 4);
            end
        end
        idle(20);
        for (int n = 0; n < 4; n++) begin
            chk(ehead[n] == etail[n], "R4/R6 all expected flits seen", ehead[n], etail[n]);
        end

        finish_run();
    end

endmodule